// File: doc/BRIEF.md
# Memory-to-Memory Bus DMA Engine

This block copies a contiguous region of memory to another address on a WISHBONE-style bus. A simple control slave port lets software set the source address, destination address and byte length, then start the transfer. A read master fetches source words into an internal FIFO. A write master drains the FIFO to the destination. Each side issues either one classic single-beat cycle per word or incrementing bursts of up to `BURST` beats, as the control register selects.

Bus responses other than a normal acknowledge are handled in the sequencers. A retry response makes the affected master drop its cycle, stay idle for `RETRY` clocks and then replay the whole burst from its first address. Words that were already captured during the failed attempt are discarded, or re-sent on the write side, by rolling back FIFO pointers. An error response ends the whole transfer at once, flushes the FIFO and latches an error flag. Completion and error both feed one active-high interrupt.

Registers (32-bit, word index on `s_adr`): 0 source address, 1 destination address, 2 length in bytes, 3 control (bit 0 start, bit 1 burst enable, bit 2 interrupt enable), 4 status (bit 0 busy, bit 1 done, bit 2 error).

Top module: `dma_engine`

## Requirements
- R1: After reset both masters hold `cyc` low, `irq` is low, and the status and control registers read 0.
- R2: A started transfer of L bytes leaves the L/STEP source words at the destination in order. Status then reads 3'b010, length reads 0, and source and destination read their start values plus L. The length register drops the low log2(STEP) bits of a write (they read back 0).
- R3: With burst enable (control bit 1) clear, every read and write bus cycle carries exactly one beat.
- R4: With burst enable set, a cycle carries at most BURST beats, and successive beats within a cycle step the address by STEP bytes.
- R5: On a read retry the read master drops `cyc` on the next clock and keeps it low for exactly RETRY clocks. It then restarts at the first address of the same burst. Words taken before the retry do not reach the destination twice or out of order.
- R6: On a write retry the write master behaves the same way and re-sends the burst from its first word, so the destination ends correct.
- R7: An error on either master drops both `cyc` on the next clock and ends the transfer with status 3'b100. The FIFO is emptied, so a following transfer copies correct data.
- R8: While busy, writes to the source, destination, length and control registers, including a new start, have no effect.
- R9: A start with length 0 sets done at once and issues no bus cycle.
- R10: `irq` equals interrupt enable AND (done OR error), one clock late. Writing 1 to status bit 1 or bit 2 clears done or error. A start clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_cyc | input | 1 | Control port cycle |
| s_stb | input | 1 | Control port strobe |
| s_we | input | 1 | Control port write enable |
| s_adr | input | 3 | Control register word index |
| s_wdat | input | 32 | Control write data |
| s_rdat | output | 32 | Control read data |
| s_ack | output | 1 | Control acknowledge |
| irq | output | 1 | Interrupt, active high |
| rd_cyc | output | 1 | Read master cycle |
| rd_stb | output | 1 | Read master strobe |
| rd_adr | output | ADR_W | Read address |
| rd_dat | input | DW | Read data |
| rd_ack | input | 1 | Read acknowledge |
| rd_rty | input | 1 | Read retry response |
| rd_err | input | 1 | Read error response |
| wr_cyc | output | 1 | Write master cycle |
| wr_stb | output | 1 | Write master strobe |
| wr_we | output | 1 | Write enable (high during write cycles) |
| wr_adr | output | ADR_W | Write address |
| wr_dat | output | DW | Write data |
| wr_ack | input | 1 | Write acknowledge |
| wr_rty | input | 1 | Write retry response |
| wr_err | input | 1 | Write error response |

## Verification
Transfers of every length from one to nine words are run in both classic and burst mode. Lengths below, equal to and above the burst size, and lengths that leave a short tail burst, show whether the burst length and the FIFO space and fill gating are computed right. Retries are placed in the middle of a read burst and of a write burst. This separates a correct rollback from one that keeps stale FIFO words or restarts at the wrong address. Errors on each master, followed by a clean transfer, show whether the flush happened. Writes during a busy transfer, a zero-length start and status clears cover the register-side corner cases.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_t;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_LEN  = 3'd2;
  localparam logic [2:0] REG_CTRL = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;

endpackage

// File: rtl/dma_seq.sv
// Burst sequencer for one master: runs a burst of blen beats, handles
// retry (idle RETRY clocks, then replay) and error (stop).
module dma_seq
  import dma_pkg::*;
#(
  parameter int MAXB  = 64,
  parameter int RETRY = 16,
  localparam int BW   = $clog2(MAXB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [BW-1:0] blen,
  input  logic          abort,
  input  logic          ack,
  input  logic          rty,
  input  logic          err,
  output logic          cyc,
  output logic [BW-1:0] idx,
  output logic          busy,
  output logic          beat,
  output logic          done,
  output logic          retry_p,
  output logic          err_p
);

  localparam logic [7:0] RT = 8'(RETRY);

  seq_state_t    state;
  logic [BW-1:0] lenq;
  logic [7:0]    timer;

  assign cyc     = (state == SEQ_RUN);
  assign busy    = (state != SEQ_IDLE);
  assign err_p   = cyc & err;
  assign retry_p = cyc & rty & ~err;
  assign beat    = cyc & ack & ~rty & ~err;
  assign done    = beat & (idx == lenq - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state <= SEQ_IDLE;
      idx   <= '0;
      lenq  <= '0;
      timer <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (go) begin
          state <= SEQ_RUN;
          idx   <= '0;
          lenq  <= blen;
        end
        SEQ_RUN: begin
          if (err) begin
            state <= SEQ_IDLE;
          end else if (rty) begin
            state <= SEQ_WAIT;
            idx   <= '0;
            timer <= RT;
          end else if (ack) begin
            if (idx == lenq - 1'b1) state <= SEQ_IDLE;
            else idx <= idx + 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (timer <= 8'd1) state <= SEQ_RUN;
          else timer <= timer - 8'd1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_fifo.sv
// FIFO with separate speculative and committed pointers on both sides,
// so a retried burst can be undone (write side) or replayed (read side).
module dma_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          wr_commit,
  input  logic          wr_undo,
  input  logic          pop,
  input  logic          rd_commit,
  input  logic          rd_undo,
  output logic [DW-1:0] rdata,
  output logic [AW:0]   free,
  output logic [AW:0]   avail
);

  localparam logic [AW:0] DEP = (AW + 1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, wc, rp, rc;

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= wdata;
  end

  assign rdata = mem[rp[AW-1:0]];
  assign free  = DEP - (wp - rc);
  assign avail = wc - rp;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      wc <= '0;
      rp <= '0;
      rc <= '0;
    end else begin
      if (wr_undo) wp <= wc;
      else if (push) wp <= wp + 1'b1;
      if (wr_commit) wc <= wp + (AW + 1)'(push);
      if (rd_undo) rp <= rc;
      else if (pop) rp <= rp + 1'b1;
      if (rd_commit) rc <= rp + (AW + 1)'(pop);
    end
  end

endmodule

// File: rtl/dma_regs.sv
// Control slave port and architectural registers of the engine.
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADR_W = 32,
  parameter int LEN_W = 32,
  parameter int SH    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_cyc,
  input  logic             s_stb,
  input  logic             s_we,
  input  logic [2:0]       s_adr,
  input  logic [31:0]      s_wdat,
  output logic [31:0]      s_rdat,
  output logic             s_ack,
  input  logic             rd_adv,
  input  logic [LEN_W-1:0] rd_bytes,
  input  logic             wr_adv,
  input  logic [LEN_W-1:0] wr_bytes,
  input  logic             fail,
  output logic             busy,
  output logic             burst_en,
  output logic [ADR_W-1:0] src_q,
  output logic [ADR_W-1:0] dst_q,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] rdl_q,
  output logic             irq
);

  localparam logic [LEN_W-1:0] LMASK = ~(LEN_W'((1 << SH) - 1));

  logic irq_en, done_q, err_q;
  logic acc, wr_acc, cfg_wr;

  assign acc    = s_cyc & s_stb & ~s_ack;
  assign wr_acc = acc & s_we;
  assign cfg_wr = wr_acc & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ack <= 1'b0;
      s_rdat <= '0;
      busy <= 1'b0;
      burst_en <= 1'b0;
      irq_en <= 1'b0;
      done_q <= 1'b0;
      err_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
      rdl_q <= '0;
      irq <= 1'b0;
    end else begin
      s_ack <= acc;
      if (acc) begin
        case (s_adr)
          REG_SRC:  s_rdat <= 32'(src_q);
          REG_DST:  s_rdat <= 32'(dst_q);
          REG_LEN:  s_rdat <= 32'(len_q);
          REG_CTRL: s_rdat <= {29'd0, irq_en, burst_en, 1'b0};
          REG_STAT: s_rdat <= {29'd0, err_q, done_q, busy};
          default:  s_rdat <= '0;
        endcase
      end
      if (cfg_wr) begin
        case (s_adr)
          REG_SRC: src_q <= s_wdat[ADR_W-1:0];
          REG_DST: dst_q <= s_wdat[ADR_W-1:0];
          REG_LEN: len_q <= s_wdat[LEN_W-1:0] & LMASK;
          REG_CTRL: begin
            burst_en <= s_wdat[1];
            irq_en   <= s_wdat[2];
            if (s_wdat[0]) begin
              err_q <= 1'b0;
              if (len_q == '0) begin
                done_q <= 1'b1;
              end else begin
                done_q <= 1'b0;
                busy   <= 1'b1;
                rdl_q  <= len_q;
              end
            end
          end
          default: ;
        endcase
      end
      if (wr_acc && s_adr == REG_STAT) begin
        if (s_wdat[1]) done_q <= 1'b0;
        if (s_wdat[2]) err_q <= 1'b0;
      end
      if (rd_adv) begin
        src_q <= src_q + ADR_W'(rd_bytes);
        rdl_q <= rdl_q - rd_bytes;
      end
      if (wr_adv) begin
        dst_q <= dst_q + ADR_W'(wr_bytes);
        len_q <= len_q - wr_bytes;
        if (len_q == wr_bytes) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (fail) begin
        busy  <= 1'b0;
        err_q <= 1'b1;
      end
      irq <= irq_en & (done_q | err_q);
    end
  end

endmodule

// File: rtl/dma_engine.sv
// Top of the DMA engine: register file, two burst sequencers, FIFO and
// the scheduling that decides when each side may start a burst.
module dma_engine #(
  parameter int ADR_W = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 32,
  parameter int BURST = 16,
  parameter int DEPTH = 32,
  parameter int RETRY = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_cyc,
  input  logic             s_stb,
  input  logic             s_we,
  input  logic [2:0]       s_adr,
  input  logic [31:0]      s_wdat,
  output logic [31:0]      s_rdat,
  output logic             s_ack,
  output logic             irq,
  output logic             rd_cyc,
  output logic             rd_stb,
  output logic [ADR_W-1:0] rd_adr,
  input  logic [DW-1:0]    rd_dat,
  input  logic             rd_ack,
  input  logic             rd_rty,
  input  logic             rd_err,
  output logic             wr_cyc,
  output logic             wr_stb,
  output logic             wr_we,
  output logic [ADR_W-1:0] wr_adr,
  output logic [DW-1:0]    wr_dat,
  input  logic             wr_ack,
  input  logic             wr_rty,
  input  logic             wr_err
);

  localparam int STEP = DW / 8;
  localparam int SH   = $clog2(STEP);
  localparam int BW   = $clog2(BURST + 1);
  localparam int FAW  = $clog2(DEPTH);

  logic             busy, burst_en, fail;
  logic [ADR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0] len_q, rdl_q, rd_beats, wr_beats, rd_bytes, wr_bytes;
  logic [BW-1:0]    rd_blen, wr_blen, rd_idx, wr_idx;
  logic             rd_go, wr_go, rd_busy, wr_busy;
  logic             rd_beat, wr_beat, rd_done, wr_done;
  logic             rd_retry, wr_retry, rd_errp, wr_errp;
  logic [FAW:0]     free, avail;

  dma_regs #(.ADR_W(ADR_W), .LEN_W(LEN_W), .SH(SH)) regs_i (
    .clk, .rst, .s_cyc, .s_stb, .s_we, .s_adr, .s_wdat, .s_rdat, .s_ack,
    .rd_adv(rd_done), .rd_bytes, .wr_adv(wr_done), .wr_bytes, .fail,
    .busy, .burst_en, .src_q, .dst_q, .len_q, .rdl_q, .irq
  );

  assign rd_beats = rdl_q >> SH;
  assign wr_beats = len_q >> SH;

  always_comb begin
    if (!burst_en) rd_blen = BW'(1);
    else if (rd_beats >= LEN_W'(BURST)) rd_blen = BW'(BURST);
    else rd_blen = BW'(rd_beats);
    if (!burst_en) wr_blen = BW'(1);
    else if (wr_beats >= LEN_W'(BURST)) wr_blen = BW'(BURST);
    else wr_blen = BW'(wr_beats);
  end

  assign rd_bytes = LEN_W'(rd_blen) << SH;
  assign wr_bytes = LEN_W'(wr_blen) << SH;
  assign fail     = rd_errp | wr_errp;

  assign rd_go = busy && (rd_beats != '0) && !rd_busy && (32'(free) >= 32'(rd_blen));
  assign wr_go = busy && (wr_beats != '0) && !wr_busy && (32'(avail) >= 32'(wr_blen));

  dma_seq #(.MAXB(BURST), .RETRY(RETRY)) rseq_i (
    .clk, .rst, .go(rd_go), .blen(rd_blen), .abort(fail),
    .ack(rd_ack), .rty(rd_rty), .err(rd_err),
    .cyc(rd_cyc), .idx(rd_idx), .busy(rd_busy), .beat(rd_beat),
    .done(rd_done), .retry_p(rd_retry), .err_p(rd_errp)
  );

  dma_seq #(.MAXB(BURST), .RETRY(RETRY)) wseq_i (
    .clk, .rst, .go(wr_go), .blen(wr_blen), .abort(fail),
    .ack(wr_ack), .rty(wr_rty), .err(wr_err),
    .cyc(wr_cyc), .idx(wr_idx), .busy(wr_busy), .beat(wr_beat),
    .done(wr_done), .retry_p(wr_retry), .err_p(wr_errp)
  );

  dma_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
    .clk, .rst, .flush(fail),
    .push(rd_beat), .wdata(rd_dat), .wr_commit(rd_done), .wr_undo(rd_retry),
    .pop(wr_beat), .rd_commit(wr_done), .rd_undo(wr_retry),
    .rdata(wr_dat), .free, .avail
  );

  assign rd_stb = rd_cyc;
  assign wr_stb = wr_cyc;
  assign wr_we  = wr_cyc;
  assign rd_adr = src_q + (ADR_W'(rd_idx) << SH);
  assign wr_adr = dst_q + (ADR_W'(wr_idx) << SH);

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int ADR_W = 32,
  parameter int DW    = 32,
  parameter int BURST = 16,
  parameter int RETRY = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_cyc,
  input logic             rd_ack,
  input logic             rd_rty,
  input logic             rd_err,
  input logic [ADR_W-1:0] rd_adr,
  input logic             wr_cyc,
  input logic             wr_ack,
  input logic             wr_rty,
  input logic             wr_err,
  input logic [ADR_W-1:0] wr_adr
);

  localparam int STEP = DW / 8;

  logic       any_err;
  logic       r_arm, w_arm;
  logic [7:0] r_gap, w_gap, r_cnt, w_cnt;

  assign any_err = (rd_cyc & rd_err) | (wr_cyc & wr_err);

  always_ff @(posedge clk) begin
    if (rst || any_err) begin
      r_arm <= 1'b0;
      r_gap <= '0;
    end else if (rd_cyc && rd_rty) begin
      r_arm <= 1'b1;
      r_gap <= '0;
    end else if (r_arm && !rd_cyc) begin
      r_gap <= r_gap + 8'd1;
    end else if (r_arm) begin
      r_arm <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || any_err) begin
      w_arm <= 1'b0;
      w_gap <= '0;
    end else if (wr_cyc && wr_rty) begin
      w_arm <= 1'b1;
      w_gap <= '0;
    end else if (w_arm && !wr_cyc) begin
      w_gap <= w_gap + 8'd1;
    end else if (w_arm) begin
      w_arm <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_cyc || rd_rty) r_cnt <= '0;
    else if (rd_ack && !rd_err) r_cnt <= r_cnt + 8'd1;
    if (rst || !wr_cyc || wr_rty) w_cnt <= '0;
    else if (wr_ack && !wr_err) w_cnt <= w_cnt + 8'd1;
  end

  a_r5_rd_drop: assert property (@(posedge clk) disable iff (rst)
    rd_cyc && rd_rty && !rd_err |=> !rd_cyc);
  a_r5_rd_gap: assert property (@(posedge clk) disable iff (rst)
    r_arm && rd_cyc |-> r_gap == 8'(RETRY));
  a_r6_wr_drop: assert property (@(posedge clk) disable iff (rst)
    wr_cyc && wr_rty && !wr_err |=> !wr_cyc);
  a_r6_wr_gap: assert property (@(posedge clk) disable iff (rst)
    w_arm && wr_cyc |-> w_gap == 8'(RETRY));
  a_r7_abort: assert property (@(posedge clk) disable iff (rst)
    any_err |=> !rd_cyc && !wr_cyc);
  a_r4_rd_len: assert property (@(posedge clk) disable iff (rst)
    rd_cyc && rd_ack |-> r_cnt < 8'(BURST));
  a_r4_wr_len: assert property (@(posedge clk) disable iff (rst)
    wr_cyc && wr_ack |-> w_cnt < 8'(BURST));
  a_r4_rd_step: assert property (@(posedge clk) disable iff (rst)
    rd_cyc && $past(rd_cyc && rd_ack && !rd_rty && !rd_err)
      |-> rd_adr == $past(rd_adr) + ADR_W'(STEP));
  a_r4_wr_step: assert property (@(posedge clk) disable iff (rst)
    wr_cyc && $past(wr_cyc && wr_ack && !wr_rty && !wr_err)
      |-> wr_adr == $past(wr_adr) + ADR_W'(STEP));

endmodule

bind dma_engine dma_engine_chk #(
  .ADR_W(ADR_W), .DW(DW), .BURST(BURST), .RETRY(RETRY)
) chk_i (
  .clk, .rst, .rd_cyc, .rd_ack, .rd_rty, .rd_err, .rd_adr,
  .wr_cyc, .wr_ack, .wr_rty, .wr_err, .wr_adr
);

// File: tb/dma_engine_tb_top.sv
module dma_engine_tb_top;

  localparam int AW = 16, DW = 32, LW = 16, BURST = 4, DEPTH = 8, RETRY = 3;
  localparam logic [15:0] SRC = 16'h0100, DST = 16'h0800;

  logic clk = 1'b0, rst = 1'b1;
  logic s_cyc = 0, s_stb = 0, s_we = 0;
  logic [2:0] s_adr = '0;
  logic [31:0] s_wdat = '0, s_rdat;
  logic s_ack, irq;
  logic rd_cyc, rd_stb, rd_ack, rd_rty, rd_err;
  logic [AW-1:0] rd_adr, wr_adr;
  logic [DW-1:0] rd_dat, wr_dat;
  logic wr_cyc, wr_stb, wr_we, wr_ack, wr_rty, wr_err;

  always #10 clk = ~clk;

  dma_engine #(.ADR_W(AW), .DW(DW), .LEN_W(LW), .BURST(BURST),
               .DEPTH(DEPTH), .RETRY(RETRY)) dut_i (
    .clk, .rst, .s_cyc, .s_stb, .s_we, .s_adr, .s_wdat, .s_rdat, .s_ack,
    .irq, .rd_cyc, .rd_stb, .rd_adr, .rd_dat, .rd_ack, .rd_rty, .rd_err,
    .wr_cyc, .wr_stb, .wr_we, .wr_adr, .wr_dat, .wr_ack, .wr_rty, .wr_err
  );

  int nchk = 0, nerr = 0;
  logic [31:0] dmem [64];
  int rdn = 0, wrn = 0, rmax = 0, wmax = 0;
  int rd_rty_at = -1, rd_err_at = -1, wr_rty_at = -1, wr_err_at = -1;

  function automatic logic [31:0] srcw(int i);
    return {8'hC3, 8'(i), 16'(i * 97 + 5)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // read-side memory responder
  initial begin : rd_resp
    int cnt, rty_t, rbeats;
    bit prev, gapw;
    logic [AW-1:0] first, rty_adr;
    cnt = 0; prev = 0; gapw = 0; rbeats = 0; first = '0; rty_adr = '0; rty_t = 0;
    rd_ack = 0; rd_rty = 0; rd_err = 0; rd_dat = '0;
    forever begin
      @(negedge clk);
      cnt++;
      rd_ack = 0; rd_rty = 0; rd_err = 0;
      if (rd_cyc && rd_stb) begin
        if (!prev) begin
          first = rd_adr; rbeats = 0;
          if (gapw) begin
            chk(cnt - rty_t == RETRY + 1, "R5 retry idle gap", 32'(cnt - rty_t - 1), 32'(RETRY));
            chk(rd_adr == rty_adr, "R5 replay start address", 32'(rd_adr), 32'(rty_adr));
            gapw = 0;
          end
        end
        if (rdn == rd_err_at) begin
          rd_err = 1; rd_err_at = -1;
        end else if (rdn == rd_rty_at) begin
          rd_rty = 1; rd_rty_at = -1; gapw = 1; rty_t = cnt; rty_adr = first;
        end else begin
          rd_ack = 1;
          rd_dat = srcw(int'((rd_adr - SRC) >> 2));
          rdn++; rbeats++;
          if (rbeats > rmax) rmax = rbeats;
        end
      end
      prev = rd_cyc;
    end
  end

  // write-side memory responder
  initial begin : wr_resp
    int cnt, rty_t, wbeats, ix;
    bit prev, gapw;
    logic [AW-1:0] first, rty_adr;
    cnt = 0; prev = 0; gapw = 0; wbeats = 0; first = '0; rty_adr = '0; rty_t = 0;
    wr_ack = 0; wr_rty = 0; wr_err = 0;
    forever begin
      @(negedge clk);
      cnt++;
      wr_ack = 0; wr_rty = 0; wr_err = 0;
      if (wr_cyc && wr_stb) begin
        if (!prev) begin
          first = wr_adr; wbeats = 0;
          if (gapw) begin
            chk(cnt - rty_t == RETRY + 1, "R6 retry idle gap", 32'(cnt - rty_t - 1), 32'(RETRY));
            chk(wr_adr == rty_adr, "R6 replay start address", 32'(wr_adr), 32'(rty_adr));
            gapw = 0;
          end
        end
        if (wrn == wr_err_at) begin
          wr_err = 1; wr_err_at = -1;
        end else if (wrn == wr_rty_at) begin
          wr_rty = 1; wr_rty_at = -1; gapw = 1; rty_t = cnt; rty_adr = first;
        end else begin
          wr_ack = 1;
          ix = int'((wr_adr - DST) >> 2);
          if (ix >= 0 && ix < 64) dmem[ix] = wr_dat;
          wrn++; wbeats++;
          if (wbeats > wmax) wmax = wbeats;
        end
      end
      prev = wr_cyc;
    end
  end

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    s_cyc = 1; s_stb = 1; s_we = 1; s_adr = a; s_wdat = d;
    do @(negedge clk); while (!s_ack);
    s_cyc = 0; s_stb = 0; s_we = 0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    s_cyc = 1; s_stb = 1; s_we = 0; s_adr = a;
    do @(negedge clk); while (!s_ack);
    d = s_rdat;
    s_cyc = 0; s_stb = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      reg_rd(3'd4, v);
      if (!v[0]) return;
    end
    chk(0, "R2 transfer never finished", 32'd1, 32'd0);
  endtask

  task automatic start(int n, bit burst, bit ie, logic [15:0] dst);
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    rdn = 0; wrn = 0; rmax = 0; wmax = 0;
    reg_wr(3'd0, 32'(SRC));
    reg_wr(3'd1, 32'(dst));
    reg_wr(3'd2, 32'(n * 4));
    reg_wr(3'd3, {29'd0, ie, burst, 1'b1});
  endtask

  function automatic int data_bad(int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (dmem[i] != srcw(i)) bad++;
    return bad;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int exp_b;
    repeat (5) @(posedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    chk(!rd_cyc && !wr_cyc && !irq, "R1 idle outputs", {29'd0, rd_cyc, wr_cyc, irq}, 32'd0);
    reg_rd(3'd4, v); chk(v == 0, "R1 status", v, 0);
    reg_rd(3'd3, v); chk(v == 0, "R1 control", v, 0);
    // R2 length low bits dropped
    reg_wr(3'd2, 32'd7); reg_rd(3'd2, v); chk(v == 4, "R2 length mask", v, 4);

    // R2/R3/R4/R10 sweep over lengths and modes
    for (int n = 1; n <= 9; n++) begin
      for (int b = 0; b < 2; b++) begin
        bit ie;
        ie = ((n + b) % 2) == 1;
        start(n, b[0], ie, DST);
        wait_idle();
        reg_rd(3'd4, v); chk(v == 32'd2, "R2 status done", v, 2);
        reg_rd(3'd2, v); chk(v == 0, "R2 length zero", v, 0);
        reg_rd(3'd0, v); chk(v == 32'(SRC) + 32'(n * 4), "R2 source end", v, 32'(SRC) + 32'(n * 4));
        reg_rd(3'd1, v); chk(v == 32'(DST) + 32'(n * 4), "R2 dest end", v, 32'(DST) + 32'(n * 4));
        chk(data_bad(n) == 0, "R2 data copied", 32'(data_bad(n)), 0);
        chk(irq == ie, "R10 irq follows enable", 32'(irq), 32'(ie));
        exp_b = b ? ((n < BURST) ? n : BURST) : 1;
        if (b) begin
          chk(rmax == exp_b && wmax == exp_b, "R4 burst beats", 32'(rmax * 256 + wmax), 32'(exp_b * 257));
        end else begin
          chk(rmax == 1 && wmax == 1, "R3 classic single beat", 32'(rmax * 256 + wmax), 32'd257);
        end
      end
    end

    // R10 write-one-to-clear
    reg_wr(3'd4, 32'h6); reg_rd(3'd4, v); chk(v == 0, "R10 done cleared", v, 0);
    @(negedge clk); @(negedge clk); chk(irq == 0, "R10 irq low after clear", 32'(irq), 0);

    // R9 zero length
    rdn = 0; wrn = 0;
    reg_wr(3'd2, 32'd0); reg_wr(3'd3, 32'h1);
    reg_rd(3'd4, v); chk(v == 32'd2, "R9 zero-length done", v, 2);
    repeat (10) @(negedge clk);
    chk(rdn == 0 && wrn == 0, "R9 no bus beats", 32'(rdn + wrn), 0);

    // R5 read retry mid burst
    rd_rty_at = 2;
    start(8, 1, 1, DST); wait_idle();
    chk(data_bad(8) == 0, "R5 data after read retry", 32'(data_bad(8)), 0);
    reg_rd(3'd4, v); chk(v == 32'd2, "R5 status", v, 2);

    // R6 write retry mid burst
    wr_rty_at = 5;
    start(8, 1, 0, DST); wait_idle();
    chk(data_bad(8) == 0, "R6 data after write retry", 32'(data_bad(8)), 0);

    // R7 read error
    rd_err_at = 3;
    start(8, 1, 1, DST); wait_idle();
    reg_rd(3'd4, v); chk(v == 32'd4, "R7 status after read error", v, 4);
    chk(!rd_cyc && !wr_cyc, "R7 masters idle", {30'd0, rd_cyc, wr_cyc}, 0);
    chk(irq == 1, "R10 irq on error", 32'(irq), 1);
    start(6, 1, 0, DST); wait_idle();
    chk(data_bad(6) == 0, "R7 clean copy after flush", 32'(data_bad(6)), 0);
    reg_rd(3'd4, v); chk(v == 32'd2, "R7 start clears error", v, 2);

    // R7 write error
    wr_err_at = 2;
    start(8, 0, 0, DST); wait_idle();
    reg_rd(3'd4, v); chk(v == 32'd4, "R7 status after write error", v, 4);
    start(7, 1, 0, DST); wait_idle();
    chk(data_bad(7) == 0, "R7 clean copy after write error", 32'(data_bad(7)), 0);

    // R8 writes while busy ignored
    start(12, 1, 1, DST);
    reg_wr(3'd2, 32'd16);
    reg_wr(3'd1, 32'h0900);
    reg_wr(3'd3, 32'h1);
    wait_idle();
    reg_rd(3'd1, v); chk(v == 32'(DST) + 48, "R8 dest register kept", v, 32'(DST) + 48);
    chk(wrn == 12, "R8 no restart", 32'(wrn), 12);
    chk(wmax == BURST, "R8 burst bit kept", 32'(wmax), 32'(BURST));
    chk(data_bad(12) == 0, "R8 data", 32'(data_bad(12)), 0);
    @(negedge clk); @(negedge clk);
    chk(irq == 1, "R8 irq enable kept", 32'(irq), 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule